// File: doc/BRIEF.md
# Floating-Point Base-2 Exponent Estimator

This block takes one IEEE-754 single-precision operand x per transaction and returns a single-precision estimate of 2^x. The answer is bit-exact to a fixed estimation recipe, not a correctly rounded power of two.

The operand is turned into a signed fixed-point number with 9 integer bits and 23 fraction bits. The integer part becomes the result exponent. The top three fraction bits select one of eight stored significands for 2^(j/8). The remaining twenty fraction bits then refine that significand by linear interpolation, using two unsigned 32x32 multiplies that keep only the upper half of the product.

Special operands are settled before the interpolation:
- NaN operands are made quiet.
- Operands whose magnitude is too large saturate to +Inf or +0.
- Operands whose magnitude is too small give 1.0.
- Results below the normal range are rounded into a denormal.

An input accepted with `in_valid` appears on `out_result` two clock edges later, with `out_valid` high for that one cycle. A new operand may be offered on every cycle.

Top module: `exp2_estimator`

## Requirements
- R1: An operand sampled with `in_valid` high at clock edge t gives `out_valid` high for exactly one cycle, after edge t+2. `out_valid` is low after reset and whenever no operand was sampled two edges earlier.
- R2: A NaN operand (exponent field 255, fraction nonzero) returns the operand unchanged except that bit 22 is set. This is the only case in which result bit 31 can be 1.
- R3: A non-NaN operand with unbiased exponent above 7 (|x| >= 256, including the infinities) returns 0x7F800000 when bit 31 is 0 and 0x00000000 when bit 31 is 1.
- R4: An operand with unbiased exponent below -23 (including both zeros and all denormals) returns 0x3F800000.
- R5: When the integer part of the fixed-point value plus 126 is 254 or more, the result is 0x7F800000. Example: x = 128.0.
- R6: When the integer part of the fixed-point value plus 126 is below -23, the result is 0x00000000. Example: x = -150.0.
- R7: Otherwise the significand comes from an eight-entry table indexed by fixed-point bits 22..20:
  - entries in index order: 0x800000, 0x8B95C2, 0x9837F0, 0xA5FED7, 0xB504F3, 0xC5672A, 0xD744FD, 0xEAC0C7;
  - correction: the fixed-point value shifted left 12 as a 32-bit word, high-multiplied by 0x172B83FF, then high-multiplied by the table entry;
  - the correction is added to the table entry;
  - if the biased exponent is 0 or more, that exponent shifted left 23 is added to the significand.
  
  Examples: 1.0 gives 0x40000000 and 0.5 gives 0x3FB504F3.
- R8: When the biased exponent k is negative (and not below -23), the significand plus 1 << (-k-1) is shifted right by -k. Example: x = -127.0 gives 0x00400000.
- R9: Negative operands use the two's-complement fixed-point value, so their fraction counts upward from the next lower integer. Example: x = -1.0 gives 0x3F000000.
- R10: Operands offered on consecutive cycles each produce their own result, in order and without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 32 | Single-precision operand x |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Single-precision estimate of 2^x |

## Verification
The hardest region to reach from the ports is the narrow band of negative operands between roughly -150 and -126. Only this band produces a denormal result with the rounding increment, or the flush to zero through the integer-part test. Operands drawn uniformly at random almost never fall there.

The stimulus therefore builds operands directly from their bit fields. It fixes the sign negative and the exponent field at 133 or 134, and randomises the fraction, so that the band is swept densely. Separate streams target the table seams (fractions near multiples of 1/8) and the saturation boundary near 128.

// File: rtl/exp2_pkg.sv
package exp2_pkg;

    localparam int FW       = 32;          // float word width
    localparam int EXPW     = 8;           // exponent field width
    localparam int MANW     = 23;          // stored fraction width
    localparam int BIAS     = 127;
    localparam int IDXW     = 3;           // table index width
    localparam int TBL_N    = 1 << IDXW;
    localparam int KW       = 10;          // signed biased-exponent width
    localparam int REMW     = MANW - IDXW; // interpolation fraction bits
    localparam int EW       = EXPW + 2;    // signed unbiased exponent width
    localparam int MAX_LSH  = 7;
    localparam int MIN_EXP  = -23;
    localparam int OUT_BIAS = 126;
    localparam int K_SAT    = 254;

    localparam logic [FW-1:0] SLOPE_K  = 32'h172B_83FF;
    localparam logic [FW-1:0] POS_INF  = 32'h7F80_0000;
    localparam logic [FW-1:0] ONE_F    = 32'h3F80_0000;
    localparam logic [FW-1:0] QUIET_B  = 32'h0040_0000;

    typedef struct packed {
        logic                  done;   // result fully decided early
        logic [FW-1:0]         early;  // that result
        logic [MANW-1:0]       pfrac;  // fraction bits of fixed-point value
        logic signed [KW-1:0]  k;      // biased result exponent
    } stage_t;

    function automatic logic [MANW:0] seed_mant(input logic [IDXW-1:0] idx);
        case (idx)
            3'd0: seed_mant = 24'h80_0000;
            3'd1: seed_mant = 24'h8B_95C2;
            3'd2: seed_mant = 24'h98_37F0;
            3'd3: seed_mant = 24'hA5_FED7;
            3'd4: seed_mant = 24'hB5_04F3;
            3'd5: seed_mant = 24'hC5_672A;
            3'd6: seed_mant = 24'hD7_44FD;
            default: seed_mant = 24'hEA_C0C7;
        endcase
    endfunction

    function automatic logic [FW-1:0] mul_hi(input logic [FW-1:0] a,
                                             input logic [FW-1:0] b);
        mul_hi = FW'((64'(a) * 64'(b)) >> FW);
    endfunction

endpackage

// File: rtl/exp2_range_decode.sv
module exp2_range_decode
    import exp2_pkg::*;
(
    input  logic [FW-1:0] operand,
    output stage_t        stage
);
    logic                 sgn;
    logic [EXPW-1:0]      efield;
    logic [MANW-1:0]      frac;
    logic signed [EW-1:0] e_unb;
    logic                 is_nan;
    logic [FW-1:0]        mag;
    logic [FW-1:0]        fixp;
    logic signed [KW-1:0] k_raw;
    logic [4:0]           rsh;

    always_comb begin
        sgn    = operand[FW-1];
        efield = operand[FW-2:MANW];
        frac   = operand[MANW-1:0];
        e_unb  = $signed({2'b00, efield}) - EW'(BIAS);
        is_nan = (efield == {EXPW{1'b1}}) && (frac != '0);
        rsh    = 5'(-e_unb);

        mag = {{(FW-MANW-1){1'b0}}, 1'b1, frac};
        if (e_unb > 0)
            mag = mag << e_unb[2:0];
        else
            mag = mag >> rsh;
        fixp  = sgn ? (~mag + 32'd1) : mag;
        k_raw = KW'($signed(fixp) >>> MANW) + KW'(OUT_BIAS);

        stage.done  = 1'b1;
        stage.early = '0;
        stage.pfrac = fixp[MANW-1:0];
        stage.k     = k_raw;

        if (e_unb > EW'(MAX_LSH)) begin
            if (is_nan)
                stage.early = operand | QUIET_B;
            else
                stage.early = sgn ? '0 : POS_INF;
        end else if (e_unb < EW'(MIN_EXP)) begin
            stage.early = ONE_F;
        end else if (k_raw >= KW'(K_SAT)) begin
            stage.early = POS_INF;
        end else if (k_raw < KW'(MIN_EXP)) begin
            stage.early = '0;
        end else begin
            stage.done = 1'b0;
        end
    end
endmodule

// File: rtl/exp2_mant_interp.sv
module exp2_mant_interp
    import exp2_pkg::*;
(
    input  stage_t        stage,
    output logic [FW-1:0] result
);
    logic [FW-1:0] base;
    logic [FW-1:0] lin;
    logic [FW-1:0] corr;
    logic [FW-1:0] mant;
    logic [4:0]    dsh;
    logic [FW-1:0] rnd;

    always_comb begin
        base = {{(FW-MANW-1){1'b0}}, seed_mant(stage.pfrac[MANW-1 -: IDXW])};
        lin  = mul_hi({stage.pfrac[REMW-1:0], 12'b0}, SLOPE_K);
        corr = mul_hi(lin, base);
        mant = base + corr;
        dsh  = 5'(-stage.k);
        rnd  = 32'd1 << (dsh - 5'd1);

        if (stage.done)
            result = stage.early;
        else if (stage.k >= 0)
            result = mant + {1'b0, stage.k[EXPW-1:0], {MANW{1'b0}}};
        else
            result = (mant + rnd) >> dsh;
    end
endmodule

// File: rtl/exp2_estimator.sv
module exp2_estimator
    import exp2_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   in_operand,
    output logic          out_valid,
    output logic [31:0]   out_result
);
    stage_t        dec_c;
    stage_t        dec_q;
    logic          v1_q;
    logic [FW-1:0] res_c;

    exp2_range_decode u_decode (
        .operand (in_operand),
        .stage   (dec_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q  <= 1'b0;
            dec_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid)
                dec_q <= dec_c;
        end
    end

    exp2_mant_interp u_interp (
        .stage  (dec_q),
        .result (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q)
                out_result <= res_c;
        end
    end
endmodule

// File: rtl/exp2_estimator_chk.sv
module exp2_estimator_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_operand,
    input logic        out_valid,
    input logic [31:0] out_result
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)
            warm <= 2'd0;
        else if (warm != 2'd2)
            warm <= warm + 2'd1;
    end

    // R1
    latency_pulse_chk: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
        out_valid == $past(in_valid, 2));

    // R2
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
        ($past(in_valid, 2) && $past(in_operand[30:23], 2) == 8'hFF &&
         $past(in_operand[22:0], 2) != 23'd0)
        |-> out_result == ($past(in_operand, 2) | 32'h0040_0000));

    // R2
    sign_only_nan_chk: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
        (out_valid && out_result[31]) |-> ($past(in_operand[30:23], 2) == 8'hFF));

    // R3
    big_pos_inf_chk: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
        ($past(in_valid, 2) && !$past(in_operand[31], 2) &&
         $past(in_operand[30:23], 2) > 8'd134 &&
         !($past(in_operand[30:23], 2) == 8'hFF && $past(in_operand[22:0], 2) != 23'd0))
        |-> out_result == 32'h7F80_0000);

    // R3
    big_neg_zero_chk: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
        ($past(in_valid, 2) && $past(in_operand[31], 2) &&
         $past(in_operand[30:23], 2) > 8'd134 &&
         !($past(in_operand[30:23], 2) == 8'hFF && $past(in_operand[22:0], 2) != 23'd0))
        |-> out_result == 32'h0000_0000);

    // R4
    tiny_one_chk: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
        ($past(in_valid, 2) && $past(in_operand[30:23], 2) < 8'd104)
        |-> out_result == 32'h3F80_0000);
endmodule

bind exp2_estimator exp2_estimator_chk chk_i (.*);

// File: tb/exp2_estimator_test.sv
`timescale 1ns/1ps
module exp2_estimator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    exp2_estimator uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic longint tbl(input longint i);
        longint t[8] = '{64'h800000, 64'h8B95C2, 64'h9837F0, 64'hA5FED7,
                         64'hB504F3, 64'hC5672A, 64'hD744FD, 64'hEAC0C7};
        return t[i];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] s);
        int ue;
        longint p, k, m, f, w, sh;
        ue = int'(s[30:23]) - 127;
        if (ue > 7) begin
            if (s[30:23] == 8'hFF && s[22:0] != 0) return s | 32'h400000;
            return s[31] ? 32'h0 : 32'h7F800000;
        end
        if (ue < -23) return 32'h3F800000;
        p = longint'({1'b1, s[22:0]});
        if (ue > 0) p = p * (longint'(1) << ue);
        else p = p / (longint'(1) << (-ue));
        if (s[31]) p = -p;
        k = (p >>> 23) + 126;
        if (k >= 254) return 32'h7F800000;
        if (k < -23) return 32'h0;
        m = tbl((p >>> 20) & 7);
        w = (p * 4096) & 64'hFFFF_FFFF;
        f = (w * 64'h172B83FF) >>> 32;
        f = (f * m) >>> 32;
        m = m + f;
        if (k >= 0) return 32'(m + k * 8388608);
        sh = -k;
        return 32'((m + (longint'(1) << (sh - 1))) >>> sh);
    endfunction

    function automatic string tag_of(input logic [31:0] s, input logic [31:0] r);
        int ue = int'(s[30:23]) - 127;
        if (s[30:23] == 8'hFF && s[22:0] != 0) return "R2";
        if (ue > 7) return "R3";
        if (ue < -23) return "R4";
        if (r == 32'h7F800000) return "R5";
        if (r == 32'h0) return "R6";
        if (r < 32'h00800000) return "R8";
        if (s[31]) return "R9";
        return "R7";
    endfunction

    // reference pipeline: operands sampled at each edge
    logic        pv0 = 0, pv1 = 0;
    logic [31:0] pd0 = '0, pd1 = '0;
    always @(posedge clk) begin
        pv0 <= in_valid && !rst;
        pd0 <= in_operand;
        pv1 <= pv0 && !rst;
        pd1 <= pd0;
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [31:0] expv;
            compared++;
            if (out_valid !== pv1) begin
                mismatched++;
                $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, pv1);
            end
            if (pv1) begin
                expv = model(pd1);
                compared++;
                if (out_result !== expv) begin
                    mismatched++;
                    $display("FAIL %s x=%08h actual=%08h expected=%08h",
                             tag_of(pd1, expv), pd1, out_result, expv);
                end
            end
        end
    end

    task automatic send(input logic [31:0] x);
        @(negedge clk);
        in_valid   <= 1'b1;
        in_operand <= x;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid <= 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R1: idle after reset
        compared++;
        if (out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset out_valid actual=%0b expected=0", out_valid);
        end
        // directed values
        send(32'h3F800000); idle(3);  // R7 1.0 -> 2.0
        send(32'h3F000000); idle(1);  // R7 0.5
        send(32'hBF800000);           // R9 -1.0
        send(32'h7FA00001);           // R2 signalling NaN
        send(32'hFFC00000);           // R2 negative quiet NaN
        send(32'h7F800000);           // R3 +Inf
        send(32'hFF800000);           // R3 -Inf
        send(32'h43800000);           // R3 256
        send(32'hC3800000);           // R3 -256
        send(32'h00000000);           // R4 +0
        send(32'h80000000);           // R4 -0
        send(32'h00000001);           // R4 denormal operand
        send(32'h33FFFFFF);           // R4 just below 2^-23
        send(32'h34000000);           // R7 2^-23
        send(32'h43000000);           // R5 128.0
        send(32'h42FE0000);           // R7 127.0
        send(32'hC3160000);           // R6 -150.0
        send(32'hC2FE0000);           // R8 -127.0
        send(32'hC3000000);           // R8 -128.0
        send(32'hC30F0000);           // R8 -143.0
        idle(2);
        // R10: dense burst through the denormal band
        for (int i = 0; i < 1500; i++)
            send({1'b1, ($urandom_range(1) != 0) ? 8'd134 : 8'd133, 23'($urandom)});
        // table seams near multiples of 1/8
        for (int i = 0; i < 600; i++) begin
            send({1'($urandom), 8'd126 - 8'($urandom_range(2)), 23'($urandom)});
            if ($urandom_range(3) == 0) idle(1);
        end
        // saturation boundary and general range
        for (int i = 0; i < 600; i++)
            send({1'($urandom), 8'd133 + 8'($urandom_range(2)), 23'($urandom)});
        for (int i = 0; i < 1500; i++)
            send($urandom);
        for (int i = 0; i < 1500; i++)
            send({1'($urandom), 8'd100 + 8'($urandom_range(40)), 23'($urandom)});
        idle(4);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule